// File: doc/BRIEF.md
# Push-Button Volume Stepper

The block turns two active-low push buttons into a 6-bit gain index that moves one step at a time. A short press gives no change. A press held past a first delay gives one step. Holding the button longer gives a second step after a longer pause. After that the index steps at a steady fast rate until the button is released or the index reaches an end of its range. All timing is counted in half-periods of a slow step clock. That clock is obtained by dividing the fast oscillator that clocks the block.

Both buttons pass through a two-flop synchroniser. The sequencer needs a steady, unbroken hold before it acts, so this also removes contact bounce. An active-low reset loads a parameterised default index. A mute input clears the output-enable flag and leaves the stored index untouched, so the same index is in force when mute is released. The mapping of the index to decibels is handled outside this block.

Top module: `vol_stepper`

## Requirements
- R1: While rst_n is low, gain_idx equals DEFAULT_IDX (40 by default) and out_en is 0. The reset acts asynchronously.
- R2: When up_n alone is held low, gain_idx increments. When dn_n alone is held low, gain_idx decrements. Every change is exactly one step.
- R3: If up_n and dn_n are both high, or both low, gain_idx does not change.
- R4: Let H be 2^HALF_TICK_LOG2 clock cycles. If a button is driven low just before clock edge number 1, the first step appears at clock edge number 3 + 7*H, which is 3.5 step-clock periods.
- R5: If the same button is still held, the second step appears 19*H cycles after the first, which is 9.5 step-clock periods.
- R6: Every later step follows the one before it by 4*H cycles, for as long as the button is held.
- R7: gain_idx stops at 63 and at 0. A request beyond either end has no effect, and the index never wraps.
- R8: A press that ends before the first step changes nothing. Releasing a button returns the sequencer to idle, so the next press waits the full first delay again.
- R9: out_en follows mute_n one cycle late. It is 0 on the edge after mute_n goes low, with no fade. Mute does not alter gain_idx, and the index still in force is kept when mute is released.
- R10: From one clock cycle to the next, gain_idx changes by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the default index |
| up_n | input | 1 | Volume-up button, active low, asynchronous |
| dn_n | input | 1 | Volume-down button, active low, asynchronous |
| mute_n | input | 1 | Low to mute (clears out_en) |
| gain_idx | output | 6 | Current gain index, 0..63 |
| out_en | output | 1 | Output enable; low while muted or in reset |

## Verification
The assertions check the following on every cycle:
- the index moves by at most one step per cycle, and never wraps;
- the index stays fixed whenever, three cycles earlier, both buttons were at the same level;
- out_en follows mute_n one cycle later.

The cycle-exact placement of the first, second and repeating steps cannot be seen in a single cycle. Neither can the restart of the delay after a release, or the fact that a short press is discarded. The bench's directed and random presses show these behaviours by comparing the index with a model of the step schedule.

// File: rtl/vol_pkg.sv
package vol_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_REPEAT
    } phase_e;

    // delays in half-periods of the step clock
    localparam int unsigned FIRST_HT  = 7;
    localparam int unsigned SECOND_HT = 19;
    localparam int unsigned REPEAT_HT = 4;
    localparam int unsigned HT_W      = $clog2(SECOND_HT + 1);
endpackage

// File: rtl/vol_sync.sv
module vol_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q, stab_q;

    // released level (all ones) during reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/vol_tick.sv
module vol_tick #(
    parameter int unsigned DIV_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
        tick_o = (&cnt_q) & ~clear_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/vol_seq.sv
module vol_seq
    import vol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_s_n,
    input  logic dn_s_n,
    input  logic tick_i,
    output logic step_o,
    output logic step_up_o,
    output logic idle_o
);
    typedef struct packed {
        phase_e          phase;
        logic [HT_W-1:0] hcnt;
        logic            dir_up;
    } seq_t;

    seq_t seq_d, seq_q;
    logic req, up_now;
    logic [HT_W-1:0] limit;

    always_comb begin
        seq_d  = seq_q;
        step_o = 1'b0;
        req    = up_s_n ^ dn_s_n;
        up_now = ~up_s_n;

        case (seq_q.phase)
            PH_FIRST:  limit = HT_W'(FIRST_HT);
            PH_SECOND: limit = HT_W'(SECOND_HT);
            default:   limit = HT_W'(REPEAT_HT);
        endcase

        if (!req || (seq_q.phase != PH_IDLE && seq_q.dir_up != up_now)) begin
            seq_d.phase = PH_IDLE;
            seq_d.hcnt  = '0;
        end else if (seq_q.phase == PH_IDLE) begin
            seq_d.phase  = PH_FIRST;
            seq_d.hcnt   = '0;
            seq_d.dir_up = up_now;
        end else if (tick_i) begin
            if (seq_q.hcnt + 1'b1 == limit) begin
                step_o     = 1'b1;
                seq_d.hcnt = '0;
                case (seq_q.phase)
                    PH_FIRST:  seq_d.phase = PH_SECOND;
                    default:   seq_d.phase = PH_REPEAT;
                endcase
            end else begin
                seq_d.hcnt = seq_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, hcnt: '0, dir_up: 1'b0};
        else        seq_q <= seq_d;
    end

    assign step_up_o = seq_q.dir_up;
    assign idle_o    = (seq_q.phase == PH_IDLE);
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper #(
    parameter int unsigned IDX_W          = 6,
    parameter int unsigned DEFAULT_IDX    = 40,
    parameter int unsigned HALF_TICK_LOG2 = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_n,
    input  logic             dn_n,
    input  logic             mute_n,
    output logic [IDX_W-1:0] gain_idx,
    output logic             out_en
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] IDX_DEF = IDX_W'(DEFAULT_IDX);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             en;
    } top_t;

    top_t top_d, top_q;
    logic [1:0] btn_s;
    logic tick, step, step_up, seq_idle;

    vol_sync #(.WIDTH(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({up_n, dn_n}),
        .sync_o (btn_s)
    );

    vol_tick #(.DIV_LOG2(HALF_TICK_LOG2)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(seq_idle),
        .tick_o (tick)
    );

    vol_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_s_n   (btn_s[1]),
        .dn_s_n   (btn_s[0]),
        .tick_i   (tick),
        .step_o   (step),
        .step_up_o(step_up),
        .idle_o   (seq_idle)
    );

    always_comb begin
        top_d    = top_q;
        top_d.en = mute_n;
        if (step) begin
            if (step_up && top_q.idx != IDX_MAX)
                top_d.idx = top_q.idx + 1'b1;
            else if (!step_up && top_q.idx != '0)
                top_d.idx = top_q.idx - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{idx: IDX_DEF, en: 1'b0};
        else        top_q <= top_d;
    end

    assign gain_idx = top_q.idx;
    assign out_en   = top_q.en;
endmodule

// File: rtl/vol_stepper_chk.sv
module vol_stepper_chk #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_n,
    input logic             dn_n,
    input logic             mute_n,
    input logic [IDX_W-1:0] gain_idx,
    input logic             out_en
);
    // R10 R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_idx != $past(gain_idx)) |->
            (({1'b0, gain_idx} == {1'b0, $past(gain_idx)} + 1'b1) ||
             ({1'b0, $past(gain_idx)} == {1'b0, gain_idx} + 1'b1)));

    // R3
    no_request_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_n, 3) == $past(dn_n, 3)) |-> $stable(gain_idx));

    // R9
    mute_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |=> !out_en);

    // R9
    mute_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_n |=> out_en);
endmodule

bind vol_stepper vol_stepper_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_n    (up_n),
    .dn_n    (dn_n),
    .mute_n  (mute_n),
    .gain_idx(gain_idx),
    .out_en  (out_en)
);

// File: tb/tb_vol_stepper.sv
module tb_vol_stepper;
    localparam int LOG2 = 3;
    localparam int H    = 1 << LOG2;
    localparam int DEF  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_n = 1'b1, dn_n = 1'b1, mute_n = 1'b1;
    logic [5:0] gain_idx;
    logic out_en;

    int checks = 0, fails = 0, exp_idx = DEF;
    bit done = 0;

    vol_stepper #(.IDX_W(6), .DEFAULT_IDX(DEF), .HALF_TICK_LOG2(LOG2)) dut (
        .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
        .mute_n(mute_n), .gain_idx(gain_idx), .out_en(out_en)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // steps produced by a hold of h cycles (press driven at a negedge, released h negedges later)
    function automatic int nsteps(int h);
        int ord = 3 + 7 * H;
        int n = 0;
        if (ord <= h + 2) begin
            n = 1;
            ord += 19 * H;
            while (ord <= h + 2) begin
                n++;
                ord += 4 * H;
            end
        end
        return n;
    endfunction

    function automatic int apply(int idx, bit up, int n);
        int r = up ? idx + n : idx - n;
        if (r > 63) r = 63;
        if (r < 0) r = 0;
        return r;
    endfunction

    task automatic hold(bit up, bit both, int h);
        @(negedge clk);
        if (both) begin up_n = 1'b0; dn_n = 1'b0; end
        else if (up) up_n = 1'b0;
        else dn_n = 1'b0;
        repeat (h) @(negedge clk);
        up_n = 1'b1; dn_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!both) exp_idx = apply(exp_idx, up, nsteps(h));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset idx", gain_idx, DEF);
        chk("R1 reset en", out_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 enable after reset", out_en, 1);

        // R4 R5 R6 exact step timing
        @(negedge clk);
        up_n = 1'b0;
        repeat (2 + 7 * H) @(negedge clk);
        chk("R4 before first step", gain_idx, DEF);
        @(negedge clk);
        chk("R4 first step", gain_idx, DEF + 1);
        repeat (19 * H - 1) @(negedge clk);
        chk("R5 before second step", gain_idx, DEF + 1);
        @(negedge clk);
        chk("R5 second step", gain_idx, DEF + 2);
        repeat (4 * H - 1) @(negedge clk);
        chk("R6 before third step", gain_idx, DEF + 2);
        @(negedge clk);
        chk("R6 third step", gain_idx, DEF + 3);
        up_n = 1'b1;
        repeat (6) @(negedge clk);
        exp_idx = DEF + 3;

        // R8 short press discarded, then restart of the delay
        hold(1'b0, 1'b0, 7 * H - 1);
        chk("R8 short press", gain_idx, exp_idx);
        hold(1'b0, 1'b0, 2 + 7 * H);
        chk("R8 restart first delay R2 down", gain_idx, exp_idx);
        chk("R2 down one step", gain_idx, DEF + 2);

        // R3 both low
        hold(1'b0, 1'b1, 400);
        chk("R3 both low", gain_idx, exp_idx);

        // R9 mute keeps index, steps still tracked
        @(negedge clk);
        mute_n = 1'b0;
        @(negedge clk);
        chk("R9 mute clears en", out_en, 0);
        chk("R9 mute keeps idx", gain_idx, exp_idx);
        hold(1'b1, 1'b0, 100);
        chk("R9 idx while muted", gain_idx, exp_idx);
        chk("R9 en stays low", out_en, 0);
        mute_n = 1'b1;
        @(negedge clk);
        chk("R9 unmute en", out_en, 1);
        chk("R9 unmute idx kept", gain_idx, exp_idx);

        // R7 clamp both ends
        hold(1'b1, 1'b0, 1200);
        chk("R7 top clamp", gain_idx, 63);
        hold(1'b1, 1'b0, 300);
        chk("R7 no wrap top", gain_idx, 63);
        hold(1'b0, 1'b0, 2500);
        chk("R7 bottom clamp", gain_idx, 0);
        hold(1'b0, 1'b0, 300);
        chk("R7 no wrap bottom", gain_idx, 0);

        // random presses: R2 R3 R8
        for (int i = 0; i < 30; i++) begin
            bit up = 1'($urandom_range(0, 1));
            bit both = ($urandom_range(0, 7) == 0);
            int h = $urandom_range(1, 700);
            hold(up, both, h);
            chk(both ? "R3 random both" : "R2 random press", gain_idx, exp_idx);
        end

        // R1 asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset idx", gain_idx, DEF);
        chk("R1 async reset en", out_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule